// File: doc/BRIEF.md
# Prefixed Two-Byte Opcode Decoder with Invalid-Opcode Trap

This block sits at the front of an instruction pipeline and receives instruction bytes one at a time over a valid/ready handshake. It follows an optional bus-lock prefix byte and the escape byte that announces a two-byte opcode. When the second opcode byte selects the group that holds the eight-byte compare-and-exchange, it reads the following addressing byte. It then produces one of three results: a decoded compare-and-exchange request, an invalid-opcode trap, or a pass-through marker for opcodes it does not handle.

The addressing byte is split into a mode field in bits [7:6], an operation field in bits [5:3] and a register-or-memory selector in bits [2:0]. The register-direct mode is illegal for this group and always traps, whether or not the lock prefix came first. A trap drops the pending bus lock in the same cycle, so that no lock can stay held after a malformed instruction. Every result lasts exactly one cycle. The decoder then goes back to waiting for the start of a new instruction.

Top module: `prefixed_op_decoder`

## Requirements
- R1: After reset, `res_valid` and `bus_lock` are low and `in_ready` is high.
- R2: When byte 0xF0 is accepted as the first byte of an instruction (or as a repeat of it), `bus_lock` is high from the next cycle until the cycle in which that instruction's result appears.
- R3: The sequence 0x0F 0xC7 followed by an addressing byte with mode bits [7:6] other than 11 and operation bits [5:3] equal to 001 yields `res_kind` = 01 (compare-exchange). `res_mode` and `res_sel` carry bits [7:6] and [2:0], and `res_lock` is 1 exactly when the 0xF0 prefix came first.
- R4: An addressing byte with mode 11 after 0x0F 0xC7 yields `res_kind` = 10 (trap), with or without the prefix. The sequence F0 0F C7 C8 traps.
- R5: An addressing byte whose operation bits [5:3] differ from 001 after 0x0F 0xC7 yields `res_kind` = 10 (trap).
- R6: In the cycle a trap result is shown, `res_lock` and `bus_lock` are both low.
- R7: A first opcode byte other than 0x0F, or a byte other than 0xC7 after 0x0F, yields `res_kind` = 11 (not handled), with that byte on `res_byte`, `res_lock` low and the lock dropped.
- R8: `res_valid` is high for one cycle per instruction, `in_ready` is low in that cycle, and the next byte then starts a new instruction.
- R9: Cycles with `in_valid` low change nothing, whatever value is on `in_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 01 compare-exchange, 10 trap, 11 not handled |
| res_lock | output | 1 | Request must run under bus lock |
| res_mode | output | 2 | Addressing mode of the request |
| res_sel | output | 3 | Register-or-memory selector of the request |
| res_byte | output | 8 | Last byte consumed by the instruction |
| bus_lock | output | 1 | Lock request held while a prefixed instruction is in flight |

## Verification
The hardest case to reach is the lock prefix running into the illegal register-direct form. In that case a lock is already held when the trap decision is made, and it must fall in the very cycle the trap is shown. The stimulus sends F0 0F C7 C8 and checks `bus_lock` between the bytes. It also repeats the same illegal bytes with idle gaps and with junk on `in_byte` while `in_valid` is low, to show that the held lock neither leaks nor is lost during the gaps.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PFX   = 2'd1,
        ST_ESC   = 2'd2,
        ST_MODRM = 2'd3
    } dec_state_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CX8  = 2'd1,
        RK_TRAP = 2'd2,
        RK_PASS = 2'd3
    } res_kind_e;

    typedef struct packed {
        dec_state_e        st;
        logic              lock;
        logic              rv;
        res_kind_e         kind;
        logic              rlock;
        logic [1:0]        mode;
        logic [2:0]        sel;
        logic [BYTE_W-1:0] last;
    } dec_regs_t;

endpackage

// File: rtl/opdec_byte_class.sv
module opdec_byte_class
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hF0,
    parameter logic [BYTE_W-1:0] ESC_CODE  = 8'h0F,
    parameter logic [BYTE_W-1:0] GRP_CODE  = 8'hC7
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_lock_o,
    output logic              is_esc_o,
    output logic              is_grp_o
);

    always_comb begin
        is_lock_o = (byte_i == LOCK_CODE);
        is_esc_o  = (byte_i == ESC_CODE);
        is_grp_o  = (byte_i == GRP_CODE);
    end

endmodule

// File: rtl/opdec_modrm_check.sv
module opdec_modrm_check
    import opdec_pkg::*;
#(
    parameter logic [1:0] REG_MODE = 2'b11,
    parameter logic [2:0] OP_CX8   = 3'b001
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [1:0]        mode_o,
    output logic [2:0]        sel_o,
    output logic              illegal_o
);

    logic [2:0] op_field;

    always_comb begin
        mode_o    = byte_i[7:6];
        op_field  = byte_i[5:3];
        sel_o     = byte_i[2:0];
        illegal_o = (mode_o == REG_MODE) || (op_field != OP_CX8);
    end

endmodule

// File: rtl/opdec_core.sv
module opdec_core
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              is_lock,
    input  logic              is_esc,
    input  logic              is_grp,
    input  logic              mr_illegal,
    input  logic [1:0]        mr_mode,
    input  logic [2:0]        mr_sel,
    output logic              in_ready,
    output dec_regs_t         regs_o
);

    dec_regs_t r_d, r_q;
    logic      accept;

    assign in_ready = !r_q.rv;
    assign accept   = in_valid && in_ready;
    assign regs_o   = r_q;

    always_comb begin
        r_d       = r_q;
        r_d.rv    = 1'b0;
        r_d.kind  = RK_NONE;
        r_d.rlock = 1'b0;
        r_d.mode  = '0;
        r_d.sel   = '0;
        if (accept) begin
            r_d.last = in_byte;
            unique case (r_q.st)
                ST_IDLE, ST_PFX: begin
                    if (is_lock) begin
                        r_d.lock = 1'b1;
                        r_d.st   = ST_PFX;
                    end else if (is_esc) begin
                        r_d.st = ST_ESC;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.lock = 1'b0;
                        r_d.rv   = 1'b1;
                        r_d.kind = RK_PASS;
                    end
                end
                ST_ESC: begin
                    if (is_grp) begin
                        r_d.st = ST_MODRM;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.lock = 1'b0;
                        r_d.rv   = 1'b1;
                        r_d.kind = RK_PASS;
                    end
                end
                ST_MODRM: begin
                    r_d.st   = ST_IDLE;
                    r_d.lock = 1'b0;
                    r_d.rv   = 1'b1;
                    if (mr_illegal) begin
                        r_d.kind = RK_TRAP;
                    end else begin
                        r_d.kind  = RK_CX8;
                        r_d.rlock = r_q.lock;
                        r_d.mode  = mr_mode;
                        r_d.sel   = mr_sel;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lock: 1'b0, rv: 1'b0, kind: RK_NONE,
                     rlock: 1'b0, mode: 2'b00, sel: 3'b000, last: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/prefixed_op_decoder.sv
module prefixed_op_decoder
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hF0,
    parameter logic [BYTE_W-1:0] ESC_CODE  = 8'h0F,
    parameter logic [BYTE_W-1:0] GRP_CODE  = 8'hC7,
    parameter logic [2:0]        OP_CX8    = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic              res_lock,
    output logic [1:0]        res_mode,
    output logic [2:0]        res_sel,
    output logic [BYTE_W-1:0] res_byte,
    output logic              bus_lock
);

    logic      is_lock, is_esc, is_grp;
    logic      mr_illegal;
    logic [1:0] mr_mode;
    logic [2:0] mr_sel;
    dec_regs_t regs;

    opdec_byte_class #(
        .LOCK_CODE (LOCK_CODE),
        .ESC_CODE  (ESC_CODE),
        .GRP_CODE  (GRP_CODE)
    ) u_class (
        .byte_i    (in_byte),
        .is_lock_o (is_lock),
        .is_esc_o  (is_esc),
        .is_grp_o  (is_grp)
    );

    opdec_modrm_check #(
        .REG_MODE (2'b11),
        .OP_CX8   (OP_CX8)
    ) u_modrm (
        .byte_i    (in_byte),
        .mode_o    (mr_mode),
        .sel_o     (mr_sel),
        .illegal_o (mr_illegal)
    );

    opdec_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .is_lock    (is_lock),
        .is_esc     (is_esc),
        .is_grp     (is_grp),
        .mr_illegal (mr_illegal),
        .mr_mode    (mr_mode),
        .mr_sel     (mr_sel),
        .in_ready   (in_ready),
        .regs_o     (regs)
    );

    assign res_valid = regs.rv;
    assign res_kind  = regs.kind;
    assign res_lock  = regs.rlock;
    assign res_mode  = regs.mode;
    assign res_sel   = regs.sel;
    assign res_byte  = regs.last;
    assign bus_lock  = regs.lock;

endmodule

// File: rtl/opdec_sva.sv
module opdec_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_byte,
    input logic       res_valid,
    input logic [1:0] res_kind,
    input logic       res_lock,
    input logic [1:0] res_mode,
    input logic       bus_lock
);

    AST_TRAP_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'b10) |-> (!res_lock && !bus_lock)); // R6

    AST_CX8_NOT_REGDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'b01) |-> (res_mode != 2'b11)); // R4

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8

    AST_NO_ACCEPT_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready); // R8

    AST_LOCK_RISES_ON_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> $past(in_valid && in_ready && in_byte == 8'hF0)); // R2

    AST_LOCK_GONE_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !bus_lock); // R2

    AST_IDLE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !res_valid && !$past(res_valid)) |=> $stable(bus_lock)); // R9

endmodule

bind prefixed_op_decoder opdec_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_lock  (res_lock),
    .res_mode  (res_mode),
    .bus_lock  (bus_lock)
);

// File: tb/sim_prefixed_op_decoder.sv
`timescale 1ns/1ps
module sim_prefixed_op_decoder;

    typedef struct packed {
        logic [1:0] kind;
        logic       lock;
        logic [1:0] mode;
        logic [2:0] sel;
        logic [7:0] last;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, res_valid, res_lock, bus_lock;
    logic [1:0] res_kind, res_mode;
    logic [2:0] res_sel;
    logic [7:0] res_byte;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    prefixed_op_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .res_valid(res_valid), .res_kind(res_kind),
        .res_lock(res_lock), .res_mode(res_mode), .res_sel(res_sel),
        .res_byte(res_byte), .bus_lock(bus_lock)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hC7;
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1 in_valid = 1'b0;
        in_byte = 8'h0F;
    endtask

    task automatic expect_res(input logic [1:0] k, input logic l,
                              input logic [1:0] m, input logic [2:0] s,
                              input logic [7:0] lb);
        exp_t e;
        e.kind = k; e.lock = l; e.mode = m; e.sel = s; e.last = lb;
        expq.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            check(in_ready == 1'b0, "R8", "ready during result", in_ready, 0);
            if (expq.size() == 0) begin
                check(1'b0, "R8", "unexpected result kind", res_kind, 0);
            end else begin
                e = expq.pop_front();
                check(res_kind == e.kind, "R3/R4/R5/R7", "res_kind", res_kind, e.kind);
                check(res_lock == e.lock, "R3/R6", "res_lock", res_lock, e.lock);
                check(bus_lock == 1'b0, "R6", "bus_lock at result", bus_lock, 0);
                if (e.kind == 2'b01) begin
                    check(res_mode == e.mode, "R3", "res_mode", res_mode, e.mode);
                    check(res_sel == e.sel, "R3", "res_sel", res_sel, e.sel);
                end
                if (e.kind == 2'b11)
                    check(res_byte == e.last, "R7", "res_byte", res_byte, e.last);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(bus_lock == 1'b0, "R1", "bus_lock after reset", bus_lock, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        rst_n = 1'b1;

        // R3 + R2: locked compare-exchange, memory form
        send(8'hF0, 0);
        @(negedge clk);
        check(bus_lock == 1'b1, "R2", "bus_lock after prefix", bus_lock, 1);
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b01, 1'b1, 2'b00, 3'b110, 8'h0E);
        send(8'h0E, 0);

        // R3 unprefixed
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b01, 1'b0, 2'b01, 3'b011, 8'h4B);
        send(8'h4B, 0);

        // R4 + R6: the critical locked register-direct form
        send(8'hF0, 0);
        send(8'h0F, 0);
        send(8'hC7, 0);
        @(negedge clk);
        check(bus_lock == 1'b1, "R4", "lock held before illegal byte", bus_lock, 1);
        expect_res(2'b10, 1'b0, 2'b00, 3'b000, 8'hC8);
        send(8'hC8, 0);
        @(negedge clk);
        check(bus_lock == 1'b0, "R6", "lock after trap", bus_lock, 0);

        // R4 unprefixed register-direct; R8 next instruction starts fresh
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b10, 1'b0, 2'b00, 3'b000, 8'hC8);
        send(8'hC8, 0);
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b01, 1'b0, 2'b00, 3'b000, 8'h08);
        send(8'h08, 0);

        // R5: wrong operation field
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b10, 1'b0, 2'b00, 3'b000, 8'h16);
        send(8'h16, 0);
        send(8'hF0, 0);
        send(8'h0F, 0);
        send(8'hC7, 0);
        expect_res(2'b10, 1'b0, 2'b00, 3'b000, 8'hBF);
        send(8'hBF, 0);

        // R7: not handled opcodes
        expect_res(2'b11, 1'b0, 2'b00, 3'b000, 8'h90);
        send(8'h90, 0);
        send(8'hF0, 0);
        expect_res(2'b11, 1'b0, 2'b00, 3'b000, 8'h90);
        send(8'h90, 0);
        send(8'h0F, 0);
        expect_res(2'b11, 1'b0, 2'b00, 3'b000, 8'h05);
        send(8'h05, 0);
        send(8'hF0, 0);
        send(8'h0F, 0);
        expect_res(2'b11, 1'b0, 2'b00, 3'b000, 8'hA2);
        send(8'hA2, 0);
        @(negedge clk);
        check(bus_lock == 1'b0, "R7", "lock after pass-through", bus_lock, 0);

        // R9: gaps with junk on in_byte
        send(8'hF0, 0);
        send(8'h0F, 3);
        @(negedge clk);
        check(bus_lock == 1'b1, "R9", "lock kept across gap", bus_lock, 1);
        send(8'hC7, 2);
        expect_res(2'b01, 1'b1, 2'b01, 3'b000, 8'h48);
        send(8'h48, 4);
        send(8'hF0, 2);
        send(8'h0F, 1);
        send(8'hC7, 3);
        expect_res(2'b10, 1'b0, 2'b00, 3'b000, 8'hC8);
        send(8'hC8, 2);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R8", "results outstanding", expq.size(), 0);
        check(bus_lock == 1'b0, "R6", "final lock", bus_lock, 0);
        finish_run();
    end

endmodule